// File: doc/BRIEF.md
# Oscillator Clock Supervisor with Quality Check

This block watches an external oscillator from a free-running reference clock. Each oscillator rising edge flips a flag in the oscillator domain. The flag is carried into the reference domain through two flops, and an edge detector there turns every change into a one-cycle edge pulse. A stall counter counts reference cycles since the last edge pulse. When it reaches the programmed limit, the monitor raises a failure. A configuration input selects the failure action: a self-clock-mode request or a system reset request. The chosen request is a level. It stays high until the block is reset or a later quality check passes.

The quality checker is a small state machine with four states: `QC_IDLE`, `QC_RUN`, `QC_PASSED` and `QC_FAILED`. It has these transitions:
- A launch moves it from idle, passed or failed into `QC_RUN` and clears both counters. A launch is a wake-up pulse or a monitor failure.
- In `QC_RUN` it counts edge pulses and window cycles.
- It moves to `QC_PASSED` in the cycle the edge target is reached. This test takes priority.
- Otherwise it moves to `QC_FAILED` on the last window cycle.
- A launch that arrives while it is in `QC_RUN` is ignored.
- The pass and fail flags hold until the next launch.

Top module: `osc_supervisor`

## Requirements
- R1: After reset, `self_clk_req`, `rst_req`, `qc_busy`, `qc_pass` and `qc_fail` are all 0.
- R2: With no oscillator edges, the monitor fails once the stall counter reaches `mon_limit`. This is at least `mon_limit` reference cycles after the oscillator stops.
- R3: On a monitor failure, `rst_req` rises if `fail_to_reset` is 1 and `self_clk_req` stays 0. If `fail_to_reset` is 0, `self_clk_req` rises and `rst_req` stays 0.
- R4: A one-cycle `wake_evt` while no check is running makes `qc_busy` 1 from the next cycle.
- R5: A monitor failure also launches a check. `qc_busy` rises in the same cycle as the request.
- R6: If `qc_edge_target` edge pulses arrive within the window, the check ends early with `qc_pass`=1 and `qc_fail`=0.
- R7: If the edge target is not reached, `qc_busy` lasts exactly `qc_window` reference cycles and ends with `qc_fail`=1 and `qc_pass`=0.
- R8: `qc_pass` and `qc_fail` keep their value until the next launch.
- R9: A `wake_evt` during a running check is ignored. The window does not restart.
- R10: The requests stay high through later failed checks and a restarted oscillator. They fall only in the cycle a check passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| osc_clk | input | 1 | Supervised oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_evt | input | 1 | Wake-up pulse (reference domain) that launches a check |
| fail_to_reset | input | 1 | Failure action: 1 reset request, 0 self-clock request |
| mon_limit | input | LIMIT_W | Stall limit in reference cycles |
| qc_edge_target | input | EDGE_W | Edge pulses needed for a pass |
| qc_window | input | WIN_W | Check window in reference cycles |
| self_clk_req | output | 1 | Self-clock-mode request (level) |
| rst_req | output | 1 | System reset request (level) |
| qc_busy | output | 1 | Quality check running |
| qc_pass | output | 1 | Last check passed |
| qc_fail | output | 1 | Last check failed |

## Verification
The assertions assume the following about the inputs:
- `mon_limit`, `qc_window` and `qc_edge_target` stay constant while the block runs.
- `mon_limit` and `qc_window` are not zero.
- The oscillator is slow enough that each flag change is seen by the two-flop synchroniser.

The bench sets the thresholds only while reset is held or the checker is idle. It runs the oscillator at a 40 ns period against the 10 ns reference, and stops or restarts it only between checks.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;
    typedef enum logic [1:0] {
        QC_IDLE   = 2'd0,
        QC_RUN    = 2'd1,
        QC_PASSED = 2'd2,
        QC_FAILED = 2'd3
    } qc_state_e;
endpackage

// File: rtl/osc_edge_sync.sv
// Turns oscillator rising edges into single-cycle pulses in the reference domain.
module osc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic edge_pulse
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic             toggle_q;
    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) toggle_q <= 1'b0;
        else        toggle_q <= ~toggle_q;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], toggle_q};
    end

    // The last stage only serves the edge detector.
    assign edge_pulse = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/osc_stall_monitor.sv
// Counts reference cycles since the last oscillator edge.
module osc_stall_monitor #(
    parameter int LIMIT_W = 16
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic               osc_edge,
    input  logic [LIMIT_W-1:0] limit,
    output logic               fail_pulse
);
    logic [LIMIT_W-1:0] stall_cnt;
    logic               expired;
    logic               expired_q;

    assign expired = (stall_cnt == limit);

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_cnt <= '0;
            expired_q <= 1'b0;
        end else begin
            expired_q <= expired;
            if (osc_edge)        stall_cnt <= '0;
            else if (!expired)   stall_cnt <= stall_cnt + 1'b1;
        end
    end

    assign fail_pulse = expired & ~expired_q;
endmodule

// File: rtl/osc_quality_fsm.sv
// Edge-count-in-window quality check.
module osc_quality_fsm
    import osc_sup_pkg::*;
#(
    parameter int EDGE_W = 8,
    parameter int WIN_W  = 16
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              osc_edge,
    input  logic [EDGE_W-1:0] edge_target,
    input  logic [WIN_W-1:0]  window,
    output logic              busy,
    output logic              passed,
    output logic              failed,
    output logic              pass_evt
);
    qc_state_e         state_q, state_d;
    logic [EDGE_W-1:0] edge_cnt;
    logic [WIN_W-1:0]  win_cnt;
    logic [EDGE_W:0]   edges_next;
    logic [WIN_W:0]    win_next;
    logic              hit;
    logic              last;
    logic              start;

    assign edges_next = {1'b0, edge_cnt} + {{EDGE_W{1'b0}}, osc_edge};
    assign win_next   = {1'b0, win_cnt} + {{WIN_W{1'b0}}, 1'b1};
    assign hit        = (edges_next >= {1'b0, edge_target});
    assign last       = (win_next >= {1'b0, window});
    assign start      = (state_q != QC_RUN) && launch;

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= QC_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QC_IDLE, QC_PASSED, QC_FAILED: begin
                if (launch) state_d = QC_RUN;
            end
            QC_RUN: begin
                if (hit)       state_d = QC_PASSED;
                else if (last) state_d = QC_FAILED;
            end
            default: state_d = QC_IDLE;
        endcase
    end

    // Counters
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            win_cnt  <= '0;
        end else if (start) begin
            edge_cnt <= '0;
            win_cnt  <= '0;
        end else if (state_q == QC_RUN) begin
            edge_cnt <= edges_next[EDGE_W-1:0];
            win_cnt  <= win_next[WIN_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        busy     = 1'b0;
        passed   = 1'b0;
        failed   = 1'b0;
        pass_evt = 1'b0;
        unique case (state_q)
            QC_IDLE:   ;
            QC_RUN: begin
                busy     = 1'b1;
                pass_evt = hit;
            end
            QC_PASSED: passed = 1'b1;
            QC_FAILED: failed = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/osc_supervisor.sv
module osc_supervisor #(
    parameter int LIMIT_W     = 16,
    parameter int EDGE_W      = 8,
    parameter int WIN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               ref_clk,
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               wake_evt,
    input  logic               fail_to_reset,
    input  logic [LIMIT_W-1:0] mon_limit,
    input  logic [EDGE_W-1:0]  qc_edge_target,
    input  logic [WIN_W-1:0]   qc_window,
    output logic               self_clk_req,
    output logic               rst_req,
    output logic               qc_busy,
    output logic               qc_pass,
    output logic               qc_fail
);
    logic osc_edge;
    logic mon_fail_pulse;
    logic pass_evt;

    osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .osc_clk    (osc_clk),
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .edge_pulse (osc_edge)
    );

    osc_stall_monitor #(.LIMIT_W(LIMIT_W)) u_mon (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .osc_edge   (osc_edge),
        .limit      (mon_limit),
        .fail_pulse (mon_fail_pulse)
    );

    osc_quality_fsm #(.EDGE_W(EDGE_W), .WIN_W(WIN_W)) u_qc (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .launch      (wake_evt | mon_fail_pulse),
        .osc_edge    (osc_edge),
        .edge_target (qc_edge_target),
        .window      (qc_window),
        .busy        (qc_busy),
        .passed      (qc_pass),
        .failed      (qc_fail),
        .pass_evt    (pass_evt)
    );

    // Failure action: set wins over clear in the same cycle.
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            self_clk_req <= 1'b0;
            rst_req      <= 1'b0;
        end else if (mon_fail_pulse) begin
            if (fail_to_reset) rst_req      <= 1'b1;
            else               self_clk_req <= 1'b1;
        end else if (pass_evt) begin
            self_clk_req <= 1'b0;
            rst_req      <= 1'b0;
        end
    end
endmodule

// File: rtl/osc_supervisor_chk.sv
module osc_supervisor_chk #(
    parameter int LIMIT_W = 16,
    parameter int WIN_W   = 16
) (
    input logic               ref_clk,
    input logic               rst_n,
    input logic               wake_evt,
    input logic               fail_to_reset,
    input logic [LIMIT_W-1:0] mon_limit,
    input logic [WIN_W-1:0]   qc_window,
    input logic               osc_edge,
    input logic               mon_fail_pulse,
    input logic               self_clk_req,
    input logic               rst_req,
    input logic               qc_busy,
    input logic               qc_pass,
    input logic               qc_fail
);
    logic [LIMIT_W-1:0] gap_q;
    logic [WIN_W:0]     run_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            run_q <= '0;
        end else begin
            if (osc_edge)         gap_q <= '0;
            else if (~&gap_q)     gap_q <= gap_q + 1'b1;
            if (qc_busy)          run_q <= run_q + 1'b1;
            else                  run_q <= '0;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge ref_clk)
        !rst_n |=> (!self_clk_req && !rst_req && !qc_busy && !qc_pass && !qc_fail));

    // R2
    stall_limit_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        mon_fail_pulse |-> (gap_q == mon_limit));

    // R3
    reset_action_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mon_fail_pulse && fail_to_reset) |=> rst_req);

    // R3
    self_action_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mon_fail_pulse && !fail_to_reset) |=> self_clk_req);

    // R4
    wake_launch_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (wake_evt && !qc_busy) |=> qc_busy);

    // R5
    fail_launch_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mon_fail_pulse && !qc_busy) |=> qc_busy);

    // R6
    one_result_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(qc_busy) |-> $onehot0({qc_pass, qc_fail}) && (qc_pass || qc_fail));

    // R7 R9
    window_len_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (qc_busy && qc_window != '0) |-> (run_q < {1'b0, qc_window}));

    // R8
    result_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!qc_busy && !wake_evt && !mon_fail_pulse) |=> ($stable(qc_pass) && $stable(qc_fail)));

    // R10
    self_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(self_clk_req) |-> $rose(qc_pass));

    // R10
    rst_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(rst_req) |-> $rose(qc_pass));
endmodule

bind osc_supervisor osc_supervisor_chk #(.LIMIT_W(LIMIT_W), .WIN_W(WIN_W)) u_chk (
    .ref_clk        (ref_clk),
    .rst_n          (rst_n),
    .wake_evt       (wake_evt),
    .fail_to_reset  (fail_to_reset),
    .mon_limit      (mon_limit),
    .qc_window      (qc_window),
    .osc_edge       (osc_edge),
    .mon_fail_pulse (mon_fail_pulse),
    .self_clk_req   (self_clk_req),
    .rst_req        (rst_req),
    .qc_busy        (qc_busy),
    .qc_pass        (qc_pass),
    .qc_fail        (qc_fail)
);

// File: tb/test_osc_supervisor.sv
`timescale 1ns/1ps
module test_osc_supervisor;
    logic        ref_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        osc_run = 1'b1;
    logic        rst_n = 1'b0;
    logic        wake_evt = 1'b0;
    logic        fail_to_reset = 1'b0;
    logic [15:0] mon_limit = 16'd32;
    logic [7:0]  qc_edge_target = 8'd8;
    logic [15:0] qc_window = 16'd64;
    logic        self_clk_req, rst_req, qc_busy, qc_pass, qc_fail;
    int          checks = 0;
    int          fails = 0;

    always #5 ref_clk = ~ref_clk;
    initial forever begin
        #20;
        if (osc_run) osc_clk = ~osc_clk;
    end

    osc_supervisor i_osc_supervisor (
        .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
        .wake_evt(wake_evt), .fail_to_reset(fail_to_reset),
        .mon_limit(mon_limit), .qc_edge_target(qc_edge_target),
        .qc_window(qc_window), .self_clk_req(self_clk_req),
        .rst_req(rst_req), .qc_busy(qc_busy), .qc_pass(qc_pass),
        .qc_fail(qc_fail)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge ref_clk);
        rst_n = 1'b1;
        repeat (12) @(negedge ref_clk);
    endtask

    // Pulses wake; returns the number of cycles busy stays high.
    task automatic run_check(output int len);
        @(negedge ref_clk) wake_evt = 1'b1;
        @(negedge ref_clk) wake_evt = 1'b0;
        len = 0;
        while (qc_busy && len < 1000) begin
            len++;
            @(negedge ref_clk);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        @(negedge ref_clk);
        check("R1 self_clk_req", self_clk_req, 0);
        check("R1 rst_req", rst_req, 0);
        check("R1 qc_busy", qc_busy, 0);
        check("R1 qc_pass", qc_pass, 0);
        check("R1 qc_fail", qc_fail, 0);
        do_reset();
    endtask

    task automatic t_pass;
        int len;
        qc_edge_target = 8'd8;
        @(negedge ref_clk) wake_evt = 1'b1;
        @(negedge ref_clk) wake_evt = 1'b0;
        check("R4 busy after wake", qc_busy, 1);
        len = 1;
        while (qc_busy && len < 1000) begin
            len++;
            @(negedge ref_clk);
        end
        check("R6 early end", int'(len < 64), 1);
        check("R6 pass", qc_pass, 1);
        check("R6 no fail", qc_fail, 0);
    endtask

    task automatic t_fail;
        int len;
        qc_edge_target = 8'd40;
        run_check(len);
        check("R7 window length", len, 64);
        check("R7 fail", qc_fail, 1);
        check("R7 no pass", qc_pass, 0);
        repeat (20) @(negedge ref_clk);
        check("R8 fail held", qc_fail, 1);
        check("R8 pass held low", qc_pass, 0);
    endtask

    task automatic t_ignore;
        int len;
        qc_edge_target = 8'd40;
        @(negedge ref_clk) wake_evt = 1'b1;
        @(negedge ref_clk) wake_evt = 1'b0;
        len = 0;
        while (qc_busy && len < 1000) begin
            len++;
            wake_evt = (len == 30);
            @(negedge ref_clk);
        end
        wake_evt = 1'b0;
        check("R9 second wake ignored", len, 64);
        @(negedge ref_clk);
        check("R9 no relaunch", qc_busy, 0);
    endtask

    task automatic t_monitor(input logic to_reset);
        int waitc;
        int len;
        fail_to_reset = to_reset;
        qc_edge_target = 8'd8;
        osc_run = 1'b0;
        waitc = 0;
        while (!(self_clk_req || rst_req) && waitc < 500) begin
            waitc++;
            @(negedge ref_clk);
        end
        check("R2 timeout not early", int'(waitc >= 32), 1);
        check("R2 timeout raised", int'(waitc < 60), 1);
        check("R3 reset request", rst_req, int'(to_reset));
        check("R3 self-clock request", self_clk_req, int'(!to_reset));
        check("R5 check launched", qc_busy, 1);
        len = 0;
        while (qc_busy && len < 1000) begin
            len++;
            @(negedge ref_clk);
        end
        check("R5 launched check fails", qc_fail, 1);
        check("R10 request held after fail", int'(self_clk_req | rst_req), 1);
        osc_run = 1'b1;
        repeat (20) @(negedge ref_clk);
        check("R10 request held after restart", int'(self_clk_req | rst_req), 1);
        run_check(len);
        check("R10 pass", qc_pass, 1);
        check("R10 self-clock cleared", self_clk_req, 0);
        check("R10 reset cleared", rst_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge ref_clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_pass();
        t_fail();
        t_ignore();
        t_monitor(1'b0);
        do_reset();
        t_monitor(1'b1);
        summary();
        $finish;
    end
endmodule